// File: doc/BRIEF.md
# SPI Port with Collision and Mode-Fault Detection

A byte-wide synchronous serial port that can run as either the clock master or a selected slave. Each transfer moves eight bits out and eight bits in at once, most significant bit first. The master drives the serial clock and sends on the master-out line. The slave answers on the master-in line while its active-low select input is held low. Software sets clock polarity and clock phase, so the port can follow either clocking convention. In master mode it also picks one of four serial clock rates derived from the system clock.

A small register interface carries configuration, status and data. Two error detectors protect the link. A data write that arrives during a transfer is refused and flagged as a collision. A master whose select input is pulled low by another device records a mode fault, drops out of master mode, disables itself and releases every output driver it owns.

Top module: `spi_port`

## Requirements
- R1: After reset the control and status registers read 0, `sck_o` is 0, and all three output enables are 0.
- R2: Register map (`bus_addr`): 0 is control, 1 is status, 2 is data. Read data appears on `bus_rdata` one cycle after the read strobe. With control bits enable (bit 0) and master (bit 1) set, a data write starts a transfer. The byte goes out MSB first on `mosi_o` while eight bits from `miso_i` are assembled, and that received byte is returned by a data read.
- R3: Control bit 2 (polarity) is the idle level of the serial clock. Control bit 3 (phase) selects the sampling edge. With phase 0, data is sampled on the edge leaving idle and the first bit is valid before any clock edge. With phase 1, data is driven on the edge leaving idle and sampled on the return edge.
- R4: Control bits 5:4 select a serial clock half-period of 4, 8, 16 or 32 system clocks (divide by 8, 16, 32, 64). The first clock edge comes one half-period after the data write, and the port produces exactly 16 edges per byte.
- R5: Status bit 7 (transfer done) is set once the 16th clock edge of a byte has been handled. It clears when status is read while it is set and the data register is accessed afterwards.
- R6: Status bit 6 (collision) is set by a data write during a transfer. That write changes neither the byte being shifted out nor the byte received. It clears by the same sequence as R5.
- R7: If the port is an enabled master and `ss_n` goes low, status bit 4 (mode fault) is set, control enable and master are cleared, and every output enable goes low. Status bit 4 clears when status is read while it is set and the control register is written afterwards.
- R8: As an enabled slave (master bit 0) with `ss_n` low, the port shifts on the edges of the external `sck_i`, samples `mosi_i`, drives `miso_o`, sets transfer done after 16 edges and returns the received byte on a data read.
- R9: A selected slave with phase 0 presents bit 7 of its loaded byte on `miso_o` before the first clock edge.
- R10: An enabled master drives `sck_oe` and `mosi_oe` and never `miso_oe`. A slave drives only `miso_oe`, and only while it is enabled and selected. A disabled port drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ss_n | input | 1 | Active-low slave select |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Master-out line, sampled as slave |
| mosi_o | output | 1 | Master-out line, driven as master |
| mosi_oe | output | 1 | Master-out driver enable |
| miso_i | input | 1 | Master-in line, sampled as master |
| miso_o | output | 1 | Master-in line, driven as slave |
| miso_oe | output | 1 | Master-in driver enable |

## Verification
The hardest state to reach from the pins is a data write that lands in the middle of a live byte. The stimulus has to hit a chosen cycle between two serial clock edges, in master mode and in slave mode. The bench times that write from its own count of system clocks since the transfer started. It then checks that the collision flag is set and that both the outgoing bits and the received byte still belong to the original transfer. The mode fault is reached by pulling the select input low under an enabled master, and the bench then checks that recovery through the status-then-control sequence works.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DW       = 8;
  localparam int RATE_W   = 2;
  localparam int HALF_MIN = 4;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = STAGES * W;
  logic [CW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/spi_port_sckgen.sv
module spi_port_sckgen #(
  parameter int RATE_W   = 2,
  parameter int HALF_MIN = 4,
  parameter int DIV_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  input  logic              cpol,
  output logic              sck_q,
  output logic              tick,
  output logic              lead
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] half_m1;

  always_comb begin
    half_m1 = DIV_W'((HALF_MIN << rate) - 1);
    tick    = run && (div_q == half_m1);
    lead    = (sck_q == cpol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      div_q <= '0;
      sck_q <= cpol;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DW    = 8,
  parameter int CNT_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          drive_idle,
  input  logic          edge_ev,
  input  logic          lead,
  input  logic          cpha,
  input  logic          din,
  output logic          out_bit,
  output logic          done_p,
  output logic [DW-1:0] rx_byte,
  output logic          cnt_zero
);
  localparam int LAST = 2 * DW - 1;

  logic [DW-1:0]    shr;
  logic [DW-1:0]    shr_nx;
  logic [CNT_W-1:0] cnt;
  logic             sample;
  logic             last;

  always_comb begin
    sample   = lead ^ cpha;
    shr_nx   = sample ? {shr[DW-2:0], din} : shr;
    last     = (cnt == CNT_W'(LAST));
    cnt_zero = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shr     <= '0;
      cnt     <= '0;
      out_bit <= 1'b0;
      done_p  <= 1'b0;
      rx_byte <= '0;
    end else begin
      done_p <= 1'b0;
      if (load) begin
        shr     <= load_byte;
        cnt     <= '0;
        out_bit <= load_byte[DW-1];
      end else if (clr) begin
        cnt <= '0;
        if (drive_idle) out_bit <= shr[DW-1];
      end else if (edge_ev) begin
        shr <= shr_nx;
        cnt <= last ? '0 : cnt + 1'b1;
        if (!sample) out_bit <= shr[DW-1];
        if (last) begin
          done_p  <= 1'b1;
          rx_byte <= shr_nx;
        end
      end else if (drive_idle && cnt_zero) begin
        out_bit <= shr[DW-1];
      end
    end
  end
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] rx_byte,
  input  logic          xfer_done,
  input  logic          busy_any,
  input  logic          sel_low,
  output ctrl_t         ctl,
  output logic          m_busy,
  output logic          load,
  output logic          done_f,
  output logic          wcol_f,
  output logic          modf_f
);
  localparam int CW = $bits(ctrl_t);

  logic wr_ctl, wr_dat, rd_sts, acc_dat, rd_any, fault;
  logic arm_dw, arm_m;
  logic [DW-1:0] sts, rd_mux;

  always_comb begin
    wr_ctl  = bus_sel && bus_wr && (bus_addr == 2'd0);
    wr_dat  = bus_sel && bus_wr && (bus_addr == 2'd2);
    rd_sts  = bus_sel && !bus_wr && (bus_addr == 2'd1);
    acc_dat = bus_sel && (bus_addr == 2'd2);
    rd_any  = bus_sel && !bus_wr;
    load    = wr_dat && !busy_any;
    fault   = ctl.en && ctl.master && sel_low;
    sts         = '0;
    sts[DW-1]   = done_f;
    sts[DW-2]   = wcol_f;
    sts[DW-4]   = modf_f;
    case (bus_addr)
      2'd0:    rd_mux = {{(DW-CW){1'b0}}, ctl};
      2'd1:    rd_mux = sts;
      2'd2:    rd_mux = rx_byte;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      m_busy    <= 1'b0;
      done_f    <= 1'b0;
      wcol_f    <= 1'b0;
      modf_f    <= 1'b0;
      arm_dw    <= 1'b0;
      arm_m     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (rd_any) bus_rdata <= rd_mux;

      if (wr_ctl) ctl <= ctrl_t'(bus_wdata[CW-1:0]);
      if (fault) begin
        ctl.en     <= 1'b0;
        ctl.master <= 1'b0;
      end

      if (fault)                         modf_f <= 1'b1;
      else if (wr_ctl && arm_m)          modf_f <= 1'b0;
      if (rd_sts && modf_f)              arm_m  <= 1'b1;
      else if (wr_ctl)                   arm_m  <= 1'b0;

      if (fault || (wr_ctl && !(bus_wdata[0] && bus_wdata[1])))
        m_busy <= 1'b0;
      else if (load && ctl.en && ctl.master)
        m_busy <= 1'b1;
      else if (xfer_done)
        m_busy <= 1'b0;

      if (xfer_done)                     done_f <= 1'b1;
      else if (acc_dat && arm_dw)        done_f <= 1'b0;
      if (wr_dat && busy_any)            wcol_f <= 1'b1;
      else if (acc_dat && arm_dw)        wcol_f <= 1'b0;
      if (rd_sts && (done_f || wcol_f))  arm_dw <= 1'b1;
      else if (acc_dat)                  arm_dw <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW          = spi_port_pkg::DW,
  parameter int RATE_W      = spi_port_pkg::RATE_W,
  parameter int HALF_MIN    = spi_port_pkg::HALF_MIN,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ss_n,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe
);
  localparam int HALF_MAX = HALF_MIN << ((1 << RATE_W) - 1);
  localparam int DIV_W    = $clog2(HALF_MAX);
  localparam int CNT_W    = $clog2(2 * DW);

  ctrl_t         ctl;
  logic          m_busy, load, done_f, wcol_f, modf_f;
  logic          xfer_done, cnt_zero, busy_any;
  logic [DW-1:0] rx_byte;
  logic          ss_s, sck_s, mosi_s, sck_d;
  logic          slave_sel, s_edge, s_lead;
  logic          m_tick, m_lead, sck_q;
  logic          edge_ev, lead, din, shf_clr, out_bit;

  spi_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_n, sck_i, mosi_i}),
    .q({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  always_comb begin
    slave_sel = ctl.en && !ctl.master && !ss_s;
    s_edge    = slave_sel && (sck_s != sck_d);
    s_lead    = (sck_s != ctl.cpol);
    edge_ev   = ctl.master ? m_tick : s_edge;
    lead      = ctl.master ? m_lead : s_lead;
    din       = ctl.master ? miso_i : mosi_s;
    busy_any  = m_busy || (slave_sel && !cnt_zero);
    shf_clr   = !ctl.en || (!ctl.master && ss_s);
  end

  spi_port_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .xfer_done(xfer_done), .busy_any(busy_any),
    .sel_low(!ss_s), .ctl(ctl), .m_busy(m_busy), .load(load),
    .done_f(done_f), .wcol_f(wcol_f), .modf_f(modf_f)
  );

  spi_port_sckgen #(.RATE_W(RATE_W), .HALF_MIN(HALF_MIN), .DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst(rst), .run(m_busy), .rate(ctl.rate), .cpol(ctl.cpol),
    .sck_q(sck_q), .tick(m_tick), .lead(m_lead)
  );

  spi_port_shifter #(.DW(DW), .CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst(rst), .clr(shf_clr), .load(load), .load_byte(bus_wdata),
    .drive_idle(!ctl.master), .edge_ev(edge_ev), .lead(lead), .cpha(ctl.cpha),
    .din(din), .out_bit(out_bit), .done_p(xfer_done), .rx_byte(rx_byte),
    .cnt_zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe  <= 1'b0;
      mosi_oe <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      sck_oe  <= ctl.en && ctl.master;
      mosi_oe <= ctl.en && ctl.master;
      miso_oe <= slave_sel;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = out_bit;
  assign miso_o = out_bit;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst,
  input logic sck_o,
  input logic sck_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic en,
  input logic master,
  input logic cpol,
  input logic m_busy,
  input logic busy_any,
  input logic done_f,
  input logic wcol_f,
  input logic modf_f
);
  // R7
  modf_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(modf_f) |=> (!sck_oe && !mosi_oe && !miso_oe));

  // R7
  modf_drop_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(modf_f) |-> (!en && !master));

  // R6
  wcol_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol_f) |-> $past(busy_any));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!m_busy && !$past(m_busy) && $stable(cpol)) |-> (sck_o == cpol));

  // R4
  sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_busy && !$stable(sck_o)) |=> $stable(sck_o));

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (master && $rose(done_f)) |-> !m_busy);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!sck_oe && !mosi_oe && !miso_oe));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst(rst), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
  .miso_oe(miso_oe), .en(ctl.en), .master(ctl.master), .cpol(ctl.cpol),
  .m_busy(m_busy), .busy_any(busy_any), .done_f(done_f), .wcol_f(wcol_f),
  .modf_f(modf_f)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ss_n = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n(ss_n), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = int'(bus_rdata);
  endtask

  // Master transfer; the reference follows sck and mosi on every clock.
  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] srx,
                        input int rate, input bit pol, input bit pha,
                        input bit collide);
    int h, t, v;
    h = 4 << rate;
    bus_write(2'd0, {2'b00, rate[1:0], pha, pol, 2'b11});
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = tx;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    for (int j = 0; j <= 16 * h + 3; j++) begin
      t = j / h;
      if (t > 16) t = 16;
      if (collide && j == 2 * h + 1) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~tx;
      end else if (collide && j == 2 * h + 2) begin
        bus_sel = 1'b0; bus_wr = 1'b0;
      end
      if (j == 1) begin
        chk("R10 master sck_oe", sck_oe, 1);
        chk("R10 master mosi_oe", mosi_oe, 1);
        chk("R10 master miso_oe", miso_oe, 0);
      end
      chk("R3 R4 sck level", sck_o, pol ^ t[0]);
      if (!pha && t < 16) chk("R2 R3 mosi bit", mosi_o, tx[7 - t / 2]);
      if (pha && t >= 1)  chk("R2 R3 mosi bit", mosi_o, tx[7 - (t - 1) / 2]);
      if (!pha) miso_i = srx[7 - ((t / 2 > 7) ? 7 : t / 2)];
      else      miso_i = (t >= 1) ? srx[7 - (t - 1) / 2] : 1'b0;
      @(negedge clk);
    end
    bus_read(2'd1, v);
    chk("R5 done set", (v >> 7) & 1, 1);
    chk("R6 collision flag", (v >> 6) & 1, int'(collide));
    bus_read(2'd2, v);
    chk("R2 received byte", v, int'(srx));
    bus_read(2'd1, v);
    chk("R5 R6 flags cleared", v, 0);
  endtask

  // Slave transfer with the bench acting as master at 16 system clocks per period.
  task automatic s_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                        input bit pol, input bit pha, input bit collide);
    int v;
    bus_write(2'd0, {4'b0000, pha, pol, 2'b01});
    bus_write(2'd2, stx);
    sck_i = pol;
    mosi_i = pha ? 1'b0 : mtx[7];
    @(negedge clk);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 slave miso_oe", miso_oe, 1);
    chk("R10 slave sck_oe", sck_oe, 0);
    if (!pha) chk("R9 first bit early", miso_o, stx[7]);
    for (int n = 1; n <= 16; n++) begin
      if (!pha && n[0])  chk("R8 miso bit", miso_o, stx[7 - (n - 1) / 2]);
      if (pha && !n[0])  chk("R8 miso bit", miso_o, stx[7 - (n - 2) / 2]);
      sck_i = pol ^ n[0];
      if (!pha && !n[0] && n < 16) mosi_i = mtx[7 - n / 2];
      if (pha && n[0])             mosi_i = mtx[7 - (n - 1) / 2];
      if (collide && n == 8) begin
        bus_write(2'd2, ~stx);
        repeat (6) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
    end
    bus_read(2'd1, v);
    chk("R8 slave done", (v >> 7) & 1, 1);
    chk("R6 slave collision", (v >> 6) & 1, int'(collide));
    bus_read(2'd2, v);
    chk("R8 slave received", v, int'(mtx));
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 deselected miso_oe", miso_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 sck_o", sck_o, 0);
    chk("R1 sck_oe", sck_oe, 0);
    chk("R1 mosi_oe", mosi_oe, 0);
    chk("R1 miso_oe", miso_oe, 0);
    bus_read(2'd0, v); chk("R1 control", v, 0);
    bus_read(2'd1, v); chk("R1 status", v, 0);

    m_xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0, 1'b0);
    m_xfer(8'h5B, 8'hE1, 3, 1'b1, 1'b1, 1'b0);
    m_xfer(8'hC3, 8'h96, 1, 1'b0, 1'b1, 1'b1);
    m_xfer(8'h1E, 8'h7D, 2, 1'b1, 1'b0, 1'b0);

    s_xfer(8'h69, 8'hB2, 1'b0, 1'b0, 1'b0);
    s_xfer(8'hD4, 8'h2B, 1'b1, 1'b1, 1'b0);
    s_xfer(8'h87, 8'h4E, 1'b0, 1'b0, 1'b1);

    // R7 mode fault
    bus_write(2'd0, 8'h03);
    @(negedge clk);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 sck_oe off", sck_oe, 0);
    chk("R7 mosi_oe off", mosi_oe, 0);
    chk("R7 miso_oe off", miso_oe, 0);
    bus_read(2'd1, v); chk("R7 fault flag", (v >> 4) & 1, 1);
    bus_read(2'd0, v); chk("R7 control cleared", v, 0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(2'd0, 8'h03);
    bus_read(2'd1, v); chk("R7 fault cleared", v, 0);
    bus_read(2'd0, v); chk("R7 control rewritten", v, 3);
    repeat (3) @(negedge clk);
    chk("R10 master again sck_oe", sck_oe, 1);
    bus_write(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10 disabled sck_oe", sck_oe, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule